// File: doc/BRIEF.md
# Serial-Flash Power State and Busy Sequencer

This block keeps track of two things for a serial-flash slave: which power state the device is in, and whether an internal write-type cycle is still running. The instruction decoder sends it single-cycle start strobes for status-register writes, page programs, sector erases and bulk erases. It also sends the decoded sleep and wake opcodes, together with a flag that says the current frame held exactly eight serial clocks. In return the block drives the busy flag (`wip`), a two-bit power-state code, and an enable that tells the decoder whether ordinary instructions may be executed.

All timing is counted in cycles of `clk`. After power-on reset, a write-inhibit timer runs for `T_PUW` cycles, and write-type starts are dropped until it expires. An accepted start holds `wip` high for a length that depends on the kind of operation. While a cycle runs, the device counts as active even if chip select has been released. Deep power-down is entered and left only at the end of a frame that carries the matching opcode and is exactly one byte long. While in deep power-down, every instruction except the wake opcode is blocked.

Top module: `flashPowerSeq`

## Requirements
- R1: `powerState` is 0 (active) when `csN` is low or `wip` is high, 1 (standby) when `csN` is high and `wip` is low, and 2 (deep power-down) whenever the device is in deep power-down, whatever the level of `csN`.
- R2: If `csN` goes high while a cycle is running, `powerState` stays 0 until the cycle's last busy cycle, and reads 1 in the cycle after `wip` falls.
- R3: The device enters deep power-down at the clock edge that samples `csN` high for the first time after being low (the frame end), provided `cmdSleep` and `frameIs8` are both high at that edge. `powerState` reads 2 from the next cycle.
- R4: A sleep opcode whose frame end arrives with `frameIs8` low has no effect.
- R5: A sleep opcode whose frame ends while `wip` is high has no effect.
- R6: In deep power-down `instrEn` is 0, and every start strobe is ignored, so `wip` stays 0.
- R7: A frame end with `cmdWake` and `frameIs8` high, seen while in deep power-down, returns the device to standby (`powerState` 1, `instrEn` 1). A wake frame outside deep power-down, or one with `frameIs8` low, changes nothing.
- R8: A start strobe is ignored until `T_PUW` clock edges have passed since reset was released.
- R9: An accepted start holds `wip` high for exactly `T_STATUS`, `T_PROGRAM`, `T_SECTOR` or `T_BULK` cycles, starting in the cycle after the strobe. If several strobes arrive together, the priority is bulk, then sector, then program, then status.
- R10: A start strobe that arrives while `wip` is high is ignored and does not extend the running cycle.
- R11: While `rstN` is low, `wip` is 0, `instrEn` is 1, and the device is not in deep power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| csN | input | 1 | Chip select, active low |
| frameIs8 | input | 1 | The current frame held exactly eight serial clocks |
| cmdSleep | input | 1 | Decoded deep power-down opcode, held through the frame end |
| cmdWake | input | 1 | Decoded release opcode, held through the frame end |
| startStatus | input | 1 | Strobe: status-register write cycle starts |
| startProgram | input | 1 | Strobe: page program cycle starts |
| startSector | input | 1 | Strobe: sector erase cycle starts |
| startBulk | input | 1 | Strobe: bulk erase cycle starts |
| wip | output | 1 | Internal cycle in progress |
| powerState | output | 2 | 0 active, 1 standby, 2 deep power-down |
| instrEn | output | 1 | Decoder may execute ordinary instructions |

## Verification
The bench sends each of the four start kinds on its own and measures the busy window of each, which shows whether the length selection is correct. A simultaneous bulk and sector strobe then checks the priority order, and a strobe sent in the middle of a cycle checks that a running cycle cannot be restarted. Sleep and wake frames are sent with a good byte flag, with a bad byte flag, while busy, and in the wrong power state. This tells apart a block that gates the frame end correctly from one that acts on the opcode alone. Strobes sent during the inhibit window and during deep power-down show whether both blocking paths hold.

// File: rtl/flashPowerPkg.sv
package flashPowerPkg;
  typedef enum logic [1:0] {
    PWR_ACTIVE  = 2'd0,
    PWR_STANDBY = 2'd1,
    PWR_DEEP    = 2'd2
  } pwrState_t;

  typedef enum logic [1:0] {
    CYC_STATUS  = 2'd0,
    CYC_PROGRAM = 2'd1,
    CYC_SECTOR  = 2'd2,
    CYC_BULK    = 2'd3
  } cycKind_t;

  typedef struct packed {
    logic     load;
    cycKind_t kind;
  } cycStrobe_t;
endpackage

// File: rtl/flashPowerData.sv
module flashPowerData
  import flashPowerPkg::*;
#(
  parameter int T_PUW     = 30,
  parameter int T_STATUS  = 40,
  parameter int T_PROGRAM = 60,
  parameter int T_SECTOR  = 100,
  parameter int T_BULK    = 150
) (
  input  logic       clk,
  input  logic       rstN,
  input  cycStrobe_t strobe,
  output logic       busy,
  output logic       puwDone
);
  localparam int MAX_A   = (T_STATUS > T_PROGRAM) ? T_STATUS : T_PROGRAM;
  localparam int MAX_B   = (T_SECTOR > T_BULK) ? T_SECTOR : T_BULK;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CYC_W   = $clog2(MAX_LEN + 1);

  logic [CYC_W-1:0] cycCnt;
  logic [CYC_W-1:0] cycLen;

  always_comb begin
    unique case (strobe.kind)
      CYC_STATUS:  cycLen = CYC_W'(T_STATUS);
      CYC_PROGRAM: cycLen = CYC_W'(T_PROGRAM);
      CYC_SECTOR:  cycLen = CYC_W'(T_SECTOR);
      default:     cycLen = CYC_W'(T_BULK);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cycCnt <= '0;
    else if (strobe.load)     cycCnt <= cycLen;
    else if (cycCnt != '0)    cycCnt <= cycCnt - 1'b1;
  end

  assign busy = (cycCnt != '0);

  // Power-up write-inhibit timer; a zero length removes it.
  generate
    if (T_PUW == 0) begin : g_noPuw
      assign puwDone = 1'b1;
    end else begin : g_puw
      localparam int PUW_W = $clog2(T_PUW + 1);
      logic [PUW_W-1:0] puwCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              puwCnt <= PUW_W'(T_PUW);
        else if (puwCnt != '0)  puwCnt <= puwCnt - 1'b1;
      end
      assign puwDone = (puwCnt == '0);
    end
  endgenerate
endmodule

// File: rtl/flashPowerCtrl.sv
module flashPowerCtrl
  import flashPowerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       frameIs8,
  input  logic       cmdSleep,
  input  logic       cmdWake,
  input  logic       startStatus,
  input  logic       startProgram,
  input  logic       startSector,
  input  logic       startBulk,
  input  logic       busy,
  input  logic       puwDone,
  output cycStrobe_t strobe,
  output logic [1:0] powerState,
  output logic       instrEn
);
  logic csPrevQ;
  logic deepQ;
  logic frameEnd;
  logic anyStart;

  assign frameEnd = csN & ~csPrevQ & frameIs8;
  assign anyStart = startStatus | startProgram | startSector | startBulk;

  always_comb begin
    strobe.load = anyStart & puwDone & ~busy & ~deepQ;
    if (startBulk)         strobe.kind = CYC_BULK;
    else if (startSector)  strobe.kind = CYC_SECTOR;
    else if (startProgram) strobe.kind = CYC_PROGRAM;
    else                   strobe.kind = CYC_STATUS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrevQ <= 1'b1;
      deepQ   <= 1'b0;
    end else begin
      csPrevQ <= csN;
      if (frameEnd && cmdSleep && !deepQ && !busy) deepQ <= 1'b1;
      else if (frameEnd && cmdWake && deepQ)       deepQ <= 1'b0;
    end
  end

  always_comb begin
    if (deepQ)              powerState = PWR_DEEP;
    else if (!csN || busy)  powerState = PWR_ACTIVE;
    else                    powerState = PWR_STANDBY;
  end

  assign instrEn = ~deepQ;
endmodule

// File: rtl/flashPowerSeq.sv
module flashPowerSeq
  import flashPowerPkg::*;
#(
  parameter int T_PUW     = 30,
  parameter int T_STATUS  = 40,
  parameter int T_PROGRAM = 60,
  parameter int T_SECTOR  = 100,
  parameter int T_BULK    = 150
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       frameIs8,
  input  logic       cmdSleep,
  input  logic       cmdWake,
  input  logic       startStatus,
  input  logic       startProgram,
  input  logic       startSector,
  input  logic       startBulk,
  output logic       wip,
  output logic [1:0] powerState,
  output logic       instrEn
);
  cycStrobe_t strobe;
  logic       busy;
  logic       puwDone;

  flashPowerCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .frameIs8(frameIs8),
    .cmdSleep(cmdSleep), .cmdWake(cmdWake),
    .startStatus(startStatus), .startProgram(startProgram),
    .startSector(startSector), .startBulk(startBulk),
    .busy(busy), .puwDone(puwDone), .strobe(strobe),
    .powerState(powerState), .instrEn(instrEn)
  );

  flashPowerData #(
    .T_PUW(T_PUW), .T_STATUS(T_STATUS), .T_PROGRAM(T_PROGRAM),
    .T_SECTOR(T_SECTOR), .T_BULK(T_BULK)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .puwDone(puwDone)
  );

  assign wip = busy;
endmodule

// File: rtl/flashPowerChk.sv
module flashPowerChk #(
  parameter int T_PUW = 30
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       wip,
  input logic [1:0] powerState,
  input logic       instrEn
);
  logic [31:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     sinceRst <= '0;
    else if (sinceRst != '1)       sinceRst <= sinceRst + 1'b1;
  end

  assert_puw_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst <= 32'(T_PUW)) |-> !wip);

  assert_busy_active_R2: assert property (@(posedge clk) disable iff (!rstN)
    (csN && wip) |-> (powerState == 2'd0));

  assert_deep_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == 2'd2) |-> (!wip && !instrEn));

  assert_no_sleep_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wip && powerState != 2'd2) |=> (powerState != 2'd2));

  assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    (powerState != 2'd2) |-> instrEn);
endmodule

bind flashPowerSeq flashPowerChk #(.T_PUW(T_PUW)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .wip(wip),
  .powerState(powerState), .instrEn(instrEn)
);

// File: tb/test_flashPowerSeq.sv
`timescale 1ns/1ps
module test_flashPowerSeq;
  localparam int P_PUW = 12, P_ST = 5, P_PP = 7, P_SE = 9, P_BE = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, frameIs8 = 1'b0, cmdSleep = 1'b0, cmdWake = 1'b0;
  logic startStatus = 1'b0, startProgram = 1'b0, startSector = 1'b0, startBulk = 1'b0;
  logic wip, instrEn;
  logic [1:0] powerState;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  int mCyc = 0, mPuw = P_PUW;
  bit mDeep = 0, mCsPrev = 1;

  always #2 clk = ~clk;

  flashPowerSeq #(.T_PUW(P_PUW), .T_STATUS(P_ST), .T_PROGRAM(P_PP),
                  .T_SECTOR(P_SE), .T_BULK(P_BE)) i_flashPowerSeq (
    .clk(clk), .rstN(rstN), .csN(csN), .frameIs8(frameIs8),
    .cmdSleep(cmdSleep), .cmdWake(cmdWake), .startStatus(startStatus),
    .startProgram(startProgram), .startSector(startSector),
    .startBulk(startBulk), .wip(wip), .powerState(powerState), .instrEn(instrEn));

  always @(posedge clk) begin
    if (!rstN) begin
      mCyc = 0; mPuw = P_PUW; mDeep = 0; mCsPrev = 1;
    end else begin
      bit fe, acc, nDeep;
      int len;
      fe  = csN && !mCsPrev && frameIs8;
      acc = (startStatus || startProgram || startSector || startBulk) &&
            mPuw == 0 && mCyc == 0 && !mDeep;
      len = startBulk ? P_BE : startSector ? P_SE : startProgram ? P_PP : P_ST;
      nDeep = mDeep;
      if (fe && cmdSleep && !mDeep && mCyc == 0) nDeep = 1;
      else if (fe && cmdWake && mDeep) nDeep = 0;
      if (acc) mCyc = len; else if (mCyc > 0) mCyc = mCyc - 1;
      if (mPuw > 0) mPuw = mPuw - 1;
      mDeep = nDeep;
      mCsPrev = csN;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check("R9 wip", int'(wip), int'(mCyc != 0));
      check("R6 instrEn", int'(instrEn), int'(!mDeep));
      check("R1 powerState", int'(powerState),
            mDeep ? 2 : ((!csN || mCyc != 0) ? 0 : 1));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse(input int kind);
    step();
    case (kind)
      0: startStatus = 1; 1: startProgram = 1; 2: startSector = 1;
      3: startBulk = 1; default: begin startSector = 1; startBulk = 1; end
    endcase
    step();
    startStatus = 0; startProgram = 0; startSector = 0; startBulk = 0;
  endtask

  task automatic measure(input string tag, input int exp);
    int n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wip) begin
        n++;
        check("R2 active while busy", int'(powerState), 0);
      end else break;
    end
    check(tag, n, exp);
    check("R2 standby after cycle", int'(powerState), 1);
  endtask

  task automatic frame(input bit sl, input bit wk, input bit f8);
    step(); csN = 0;
    repeat (3) step();
    csN = 1; cmdSleep = sl; cmdWake = wk; frameIs8 = f8;
    step(); cmdSleep = 0; cmdWake = 0; frameIs8 = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset wip", int'(wip), 0);
    check("R11 reset instrEn", int'(instrEn), 1);
    check("R11 reset state", int'(powerState), 1);
    step(); rstN = 1;
    // R8: start inside inhibit window
    pulse(1);
    @(negedge clk); check("R8 inhibited start", int'(wip), 0);
    repeat (P_PUW + 2) step();
    // R9: each kind
    pulse(0); measure("R9 status length", P_ST);
    pulse(1); measure("R9 program length", P_PP);
    pulse(2); measure("R9 sector length", P_SE);
    pulse(3); measure("R9 bulk length", P_BE);
    pulse(4); measure("R9 bulk over sector priority", P_BE);
    // R10: restart attempt mid-cycle
    pulse(1); pulse(3);
    measure("R10 no restart", P_PP - 2);
    // R4: bad length frame
    frame(1, 0, 0);
    check("R4 short sleep frame", int'(powerState), 1);
    // R5: sleep while busy
    pulse(3);
    frame(1, 0, 1);
    check("R5 sleep while busy", int'(powerState), 0);
    repeat (P_BE) step();
    @(negedge clk); check("R5 not deep after cycle", int'(powerState), 1);
    // R3: proper sleep
    frame(1, 0, 1);
    check("R3 deep entered", int'(powerState), 2);
    check("R6 instrEn low", int'(instrEn), 0);
    pulse(1);
    @(negedge clk); check("R6 start ignored in deep", int'(wip), 0);
    step(); csN = 0;
    @(negedge clk); check("R1 deep with cs low", int'(powerState), 2);
    step(); csN = 1;
    // R7: wake with bad length, then good
    frame(0, 1, 0);
    check("R7 short wake frame", int'(powerState), 2);
    frame(0, 1, 1);
    check("R7 wake to standby", int'(powerState), 1);
    check("R7 instrEn restored", int'(instrEn), 1);
    frame(0, 1, 1);
    check("R7 wake outside deep", int'(powerState), 1);
    step(); csN = 0;
    @(negedge clk); check("R1 active with cs low", int'(powerState), 0);
    step(); csN = 1;
    repeat (3) step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule